// File: doc/BRIEF.md
# Eight-Input Half Classifier

This block splits eight unsigned words into two groups of four. The four smallest values go to the low group and the four largest go to the high group. The order of the words inside either group is not defined. Only the partition is guaranteed, and the contents of each group are unordered. Because of that, the network needs fewer compare-exchange elements and fewer levels than a full eight-word sorter.

The network has two stages. First, each half of the input is sorted with a five-element, three-level four-word sorter. Then a single level of four compare-exchange elements pairs position i of one sorted half with position 3−i of the other. The minimum of each pair goes to the low group and the maximum to the high group. That makes fourteen elements in four levels. A full eight-word merge sorter uses nineteen.

The result is registered once. Outputs therefore show the classification of the inputs captured at the previous rising clock edge. An active-low asynchronous reset clears both groups to zero.

Top module: `half_classifier8`

## Requirements
- R1: While reset is asserted, and after it, until the first clock edge with reset released, every word of both output groups is zero.
- R2: The groups on the outputs belong to the input vector captured at the previous rising clock edge: one cycle of latency.
- R3: Every word in the low group is less than or equal to every word in the high group, compared as unsigned numbers. Equal values may fall on both sides.
- R4: The eight output words taken together are the same multiset as the eight captured input words. Nothing is lost and nothing is duplicated.
- R5: When every input word is 0 or 1, the low group holds exactly min(z, 4) zero words, where z is the number of zero inputs.
- R6: The network is built from CMP_COUNT = 14 compare-exchange elements, strictly fewer than the 19 of a full eight-word sorter.
- R7: When all eight inputs are equal, all eight outputs carry that value.
- R8: The low group, sorted, equals the four smallest input words in ascending order, for ascending, descending and mixed input orders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 8×W | Eight unsigned words; din[k] is word k |
| lo | output | 4×W | Registered group of the four smallest words, unordered |
| hi | output | 4×W | Registered group of the four largest words, unordered |

## Verification
The bench builds the block with W = 8. At this width, hand-picked vectors with extreme values, 0 and 255, are available. So are random vectors drawn from only four distinct levels, which forces many duplicates across the group boundary. At the same width, all 256 zero-one patterns can be applied as one-bit values inside full-width words, which covers every way the partition can be split. The comparator count is read from the instance parameter and checked against the full-sorter bound.

// File: rtl/half_classifier8.sv
`timescale 1ns/1ps
module half_classifier8 #(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0][W-1:0]  din,
  output logic [3:0][W-1:0]  lo,
  output logic [3:0][W-1:0]  hi
);
  localparam int QUAD      = 4;
  localparam int QSORT_CMP = 5;
  localparam int CMP_COUNT = 2 * QSORT_CMP + QUAD;
  localparam int DEPTH     = 4;

  function automatic logic [W-1:0] vmin(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [W-1:0] vmax(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a < b) ? b : a;
  endfunction

  logic [1:0][3:0][W-1:0] s0, s1, s2, s3;
  logic [3:0][W-1:0]      lo_d, hi_d;

  for (genvar h = 0; h < 2; h++) begin : g_quad
    for (genvar i = 0; i < QUAD; i++) begin : g_in
      assign s0[h][i] = din[QUAD*h + i];
    end
    assign s1[h][0] = vmin(s0[h][0], s0[h][1]);
    assign s1[h][1] = vmax(s0[h][0], s0[h][1]);
    assign s1[h][2] = vmin(s0[h][2], s0[h][3]);
    assign s1[h][3] = vmax(s0[h][2], s0[h][3]);

    assign s2[h][0] = vmin(s1[h][0], s1[h][2]);
    assign s2[h][2] = vmax(s1[h][0], s1[h][2]);
    assign s2[h][1] = vmin(s1[h][1], s1[h][3]);
    assign s2[h][3] = vmax(s1[h][1], s1[h][3]);

    assign s3[h][0] = s2[h][0];
    assign s3[h][1] = vmin(s2[h][1], s2[h][2]);
    assign s3[h][2] = vmax(s2[h][1], s2[h][2]);
    assign s3[h][3] = s2[h][3];
  end

  for (genvar i = 0; i < QUAD; i++) begin : g_split
    assign lo_d[i] = vmin(s3[0][i], s3[1][QUAD-1-i]);
    assign hi_d[i] = vmax(s3[0][i], s3[1][QUAD-1-i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_d;
      hi <= hi_d;
    end
  end
endmodule

// File: rtl/half_classifier8_chk.sv
`timescale 1ns/1ps
module half_classifier8_chk #(
  parameter int W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [7:0][W-1:0]  din,
  input logic [3:0][W-1:0]  lo,
  input logic [3:0][W-1:0]  hi
);
  logic [W-1:0] max_lo, min_hi, min_in, max_in, min_out, max_out;
  logic [W+2:0] sum_in, sum_out;
  logic [3:0]   zin, zlo;
  logic         bin_in, seen;

  always_comb begin
    max_lo = lo[0]; min_hi = hi[0];
    sum_out = '0; zlo = '0;
    for (int i = 0; i < 4; i++) begin
      if (lo[i] > max_lo) max_lo = lo[i];
      if (hi[i] < min_hi) min_hi = hi[i];
      sum_out = sum_out + (W+3)'(lo[i]) + (W+3)'(hi[i]);
      if (lo[i] == '0) zlo = zlo + 4'd1;
    end
    min_out = (lo[0] < lo[1]) ? lo[0] : lo[1];
    for (int i = 2; i < 4; i++) if (lo[i] < min_out) min_out = lo[i];
    max_out = (hi[0] > hi[1]) ? hi[0] : hi[1];
    for (int i = 2; i < 4; i++) if (hi[i] > max_out) max_out = hi[i];
    min_in = din[0]; max_in = din[0];
    sum_in = '0; zin = '0; bin_in = 1'b1;
    for (int k = 0; k < 8; k++) begin
      if (din[k] < min_in) min_in = din[k];
      if (din[k] > max_in) max_in = din[k];
      sum_in = sum_in + (W+3)'(din[k]);
      if (din[k] == '0) zin = zin + 4'd1;
      if (din[k] > W'(1)) bin_in = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r3_partition: assert property (@(posedge clk) disable iff (!rst_n)
    max_lo <= min_hi);

  a_r4_sum_kept: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> sum_out == $past(sum_in));

  a_r2_min_max_follow: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (min_out == $past(min_in) && max_out == $past(max_in)));

  a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(bin_in)) |-> zlo == (($past(zin) > 4'd4) ? 4'd4 : $past(zin)));
endmodule

bind half_classifier8 half_classifier8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .lo(lo), .hi(hi)
);

// File: tb/half_classifier8_tb.sv
`timescale 1ns/1ps
module half_classifier8_tb;
  localparam int W    = 8;
  localparam int NVEC = 6;

  localparam logic [7:0][W-1:0] VIN [NVEC] = '{
    {8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0},
    {8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7},
    {8'd9, 8'd200, 8'd17, 8'd4, 8'd4, 8'd250, 8'd1, 8'd30},
    {8'd255, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0, 8'd255, 8'd0},
    {8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd5},
    {8'd100, 8'd3, 8'd100, 8'd3, 8'd50, 8'd50, 8'd2, 8'd99}
  };
  localparam logic [3:0][W-1:0] VLO [NVEC] = '{
    {8'd3, 8'd2, 8'd1, 8'd0},
    {8'd3, 8'd2, 8'd1, 8'd0},
    {8'd9, 8'd4, 8'd4, 8'd1},
    {8'd0, 8'd0, 8'd0, 8'd0},
    {8'd5, 8'd5, 8'd5, 8'd5},
    {8'd50, 8'd3, 8'd3, 8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0][W-1:0] din = '0;
  logic [3:0][W-1:0] lo, hi;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  half_classifier8 #(.W(W)) u_dut (.clk(clk), .rst_n(rst_n), .din(din), .lo(lo), .hi(hi));

  function automatic logic [7:0][W-1:0] sort8(input logic [7:0][W-1:0] v);
    logic [W-1:0] t;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 7 - i; j++)
        if (v[j] > v[j+1]) begin t = v[j]; v[j] = v[j+1]; v[j+1] = t; end
    return v;
  endfunction

  function automatic logic [3:0][W-1:0] sort4(input logic [3:0][W-1:0] v);
    logic [W-1:0] t;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 3 - i; j++)
        if (v[j] > v[j+1]) begin t = v[j]; v[j] = v[j+1]; v[j+1] = t; end
    return v;
  endfunction

  task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0][W-1:0] v);
    @(negedge clk) din = v;
    @(negedge clk);
  endtask

  task automatic check_split(input string req, input logic [7:0][W-1:0] v);
    logic [7:0][W-1:0] s;
    logic [3:0][W-1:0] sl, sh;
    s  = sort8(v);
    sl = sort4(lo);
    sh = sort4(hi);
    check(req, sl == s[3:0], 64'(sl), 64'(s[3:0]));
    check(req, sh == s[7:4], 64'(sh), 64'(s[7:4]));
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    #1;
    check("R1", lo == '0 && hi == '0, 64'({lo, hi}), 64'd0);
    din = {8{8'd77}};
    repeat (3) @(negedge clk);
    check("R1", lo == '0 && hi == '0, 64'({lo, hi}), 64'd0);
    rst_n = 1'b1;
    check("R1", lo == '0 && hi == '0, 64'({lo, hi}), 64'd0);

    // R6: comparator budget
    check("R6", u_dut.CMP_COUNT == 14 && u_dut.CMP_COUNT < 19, 64'(u_dut.CMP_COUNT), 64'd14);

    // R8 / R7: table of vectors
    for (int n = 0; n < NVEC; n++) begin
      apply(VIN[n]);
      check("R8", sort4(lo) == VLO[n], 64'(sort4(lo)), 64'(VLO[n]));
      check_split("R4", VIN[n]);
    end
    apply({8{8'd200}});
    check("R7", lo == {4{8'd200}} && hi == {4{8'd200}}, 64'({lo, hi}), 64'({8{8'd200}}));

    // R2: one cycle latency
    @(negedge clk) din = {8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1};
    @(posedge clk); #1;
    din = {8{8'd250}};
    check("R2", sort4(lo) == {8'd4, 8'd3, 8'd2, 8'd1}, 64'(sort4(lo)), 64'h04030201);
    @(negedge clk);
    check("R2", sort4(lo) == {8'd4, 8'd3, 8'd2, 8'd1}, 64'(sort4(lo)), 64'h04030201);
    @(posedge clk); #1;
    check("R2", lo == {4{8'd250}}, 64'(lo), 64'({4{8'd250}}));

    // R5: all zero-one patterns
    for (int p = 0; p < 256; p++) begin
      logic [7:0][W-1:0] v;
      int z, zl, ze;
      z = 0; zl = 0;
      for (int k = 0; k < 8; k++) begin
        v[k] = W'(p[k]);
        if (!p[k]) z++;
      end
      apply(v);
      for (int i = 0; i < 4; i++) if (lo[i] == '0) zl++;
      ze = (z > 4) ? 4 : z;
      check("R5", zl == ze, 64'(zl), 64'(ze));
    end

    // R3 / R4: random vectors with heavy duplication
    for (int r = 0; r < 400; r++) begin
      logic [7:0][W-1:0] v;
      logic [W-1:0] mx, mn;
      for (int k = 0; k < 8; k++) v[k] = W'($urandom_range(0, 3) * 85);
      apply(v);
      mx = lo[0]; mn = hi[0];
      for (int i = 1; i < 4; i++) begin
        if (lo[i] > mx) mx = lo[i];
        if (hi[i] < mn) mn = hi[i];
      end
      check("R3", mx <= mn, 64'(mx), 64'(mn));
      check_split("R4", v);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule